// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Unit

This unit is a signed multiplier for an integer execution pipeline. It has two operand modes. In halfword mode, one 16-bit half is taken from each 32-bit source, and the two halves are multiplied to give a 32-bit product. In word mode, the whole first source is multiplied by one 16-bit half of the second source, and only the middle 32 bits of the 48-bit product are kept. Either form can add an accumulator value to its product. Only these accumulating forms can set a sticky overflow flag, which holds its value until a synchronous clear.

Instruction decode and the register file sit outside the block. Decode supplies the register indices and the operand values. A single-cycle valid strobe starts an operation. The result, the write enable and the unpredictable indication are registered and appear one clock later. Any register index that takes part in the operation and equals 15 makes the operation unpredictable. An unpredictable operation writes nothing and leaves the flag alone.

Top module: `halfsel_mac`

## Requirements
- R1: In halfword mode (`mode`=0), `sel_a_top`=1 selects bits [31:16] of `src_a` and `sel_a_top`=0 selects bits [15:0]. `sel_b_top` selects from `src_b` in the same way. Each selected half is treated as a signed 16-bit value.
- R2: Halfword mode with `acc_en`=0 writes the 32-bit signed product of the two halves. It leaves `ovf_flag` unchanged.
- R3: Halfword mode with `acc_en`=1 writes the product plus `acc_in`, modulo 2^32. A signed overflow in that addition sets `ovf_flag`.
- R4: In word mode (`mode`=1), signed `src_a` is multiplied by the signed half of `src_b` chosen by `sel_b_top` (1 = bits [31:16]). The result is bits [47:16] of the 48-bit product. `sel_a_top` has no effect in this mode.
- R5: Word mode with `acc_en`=1 adds `acc_in` to that 32-bit value, modulo 2^32. A signed overflow sets `ovf_flag`. Word mode with `acc_en`=0 never changes the flag.
- R6: An operation is unpredictable when `idx_dst`, `idx_a` or `idx_b` equals 15, or when `acc_en`=1 and `idx_acc` equals 15. Such an operation gives `unpred`=1 and `res_we`=0, and it leaves `ovf_flag` unchanged.
- R7: `ovf_flag` is sticky and only `flag_clr` clears it. The clear is synchronous and takes effect at the next clock edge. When a clear and a set fall in the same cycle, the clear wins.
- R8: `res_out`, `res_we`, `unpred` and the flag update appear one clock after the valid cycle. A cycle without `in_valid` gives `res_we`=0 and `unpred`=0 on the next cycle.
- R9: After reset, `res_out`=0, `res_we`=0, `unpred`=0 and `ovf_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 1 | 0 = halfword x halfword, 1 = word x halfword |
| sel_a_top | input | 1 | Take the upper half of src_a (halfword mode) |
| sel_b_top | input | 1 | Take the upper half of src_b |
| acc_en | input | 1 | Add acc_in to the product |
| src_a | input | 32 | First source |
| src_b | input | 32 | Second source |
| acc_in | input | 32 | Accumulator value |
| idx_dst | input | 4 | Destination register index |
| idx_a | input | 4 | Index of src_a |
| idx_b | input | 4 | Index of src_b |
| idx_acc | input | 4 | Index of acc_in |
| flag_clr | input | 1 | Synchronous clear of ovf_flag |
| res_out | output | 32 | Registered result |
| res_we | output | 1 | Result write enable |
| unpred | output | 1 | Operation was unpredictable |
| ovf_flag | output | 1 | Sticky accumulate-overflow flag |

## Verification
Every result, write enable, unpredictable indication and flag update is due exactly one clock after the cycle that presented it. The bench drives each operation on a falling edge, then advances its behavioural model across the next rising edge. It compares all four outputs on the falling edge that follows, so each comparison lands in the single cycle where the registered value is first valid. Idle cycles go through the same comparison, which checks that a cycle without a strobe gives no write and no unpredictable indication.

// File: rtl/halfsel_mac_pkg.sv
package halfsel_mac_pkg;
   typedef enum logic {
      MODE_HALF = 1'b0,
      MODE_WORD = 1'b1
   } mac_mode_e;

   localparam int unsigned OPND_SLOTS = 4;
endpackage

// File: rtl/hsm_half_pick.sv
module hsm_half_pick #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned HALF_W = DATA_W / 2
) (
   input  logic [DATA_W-1:0]        word_in,
   input  logic                     take_top,
   output logic signed [HALF_W-1:0] half_out
);
   initial begin
      assert (DATA_W % 2 == 0) else $error("DATA_W must be even");
   end

   always_comb begin
      if (take_top) half_out = $signed(word_in[DATA_W-1:HALF_W]);
      else          half_out = $signed(word_in[HALF_W-1:0]);
   end
endmodule

// File: rtl/hsm_product.sv
module hsm_product
   import halfsel_mac_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          WORD_MODE = 1'b1,
   localparam int unsigned HALF_W = DATA_W / 2,
   localparam int unsigned WIDE_W = DATA_W + HALF_W
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              a_top,
   input  logic              b_top,
   input  mac_mode_e         mode_sel,
   output logic [DATA_W-1:0] prod_out
);
   logic signed [HALF_W-1:0] half_a;
   logic signed [HALF_W-1:0] half_b;
   logic signed [DATA_W-1:0] prod_hh;

   hsm_half_pick #(.DATA_W(DATA_W)) u_pick_a (
      .word_in(opnd_a), .take_top(a_top), .half_out(half_a));
   hsm_half_pick #(.DATA_W(DATA_W)) u_pick_b (
      .word_in(opnd_b), .take_top(b_top), .half_out(half_b));

   // a signed 16x16 product always fits in 32 bits
   always_comb prod_hh = DATA_W'(half_a) * DATA_W'(half_b);

   generate
      if (WORD_MODE) begin : g_word
         logic signed [WIDE_W-1:0] wide;
         always_comb begin
            wide = WIDE_W'($signed(opnd_a)) * WIDE_W'(half_b);
            if (mode_sel == MODE_WORD) prod_out = wide[WIDE_W-1:HALF_W];
            else                       prod_out = prod_hh;
         end
      end else begin : g_half_only
         always_comb prod_out = prod_hh;
      end
   endgenerate
endmodule

// File: rtl/hsm_acc_add.sv
module hsm_acc_add #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] sum,
   output logic              sgn_ovf
);
   always_comb begin
      sum     = lhs + rhs;
      sgn_ovf = (lhs[DATA_W-1] == rhs[DATA_W-1]) && (sum[DATA_W-1] != lhs[DATA_W-1]);
   end
endmodule

// File: rtl/hsm_idx_check.sv
module hsm_idx_check #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned SLOTS   = 4,
   parameter int unsigned BAD_IDX = 15
) (
   input  logic [SLOTS*IDX_W-1:0] idx_flat,
   input  logic [SLOTS-1:0]       slot_used,
   output logic                   any_bad
);
   logic [SLOTS-1:0] hit;

   initial begin
      assert (BAD_IDX < (1 << IDX_W)) else $error("BAD_IDX does not fit IDX_W");
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         assign hit[s] = slot_used[s] && (idx_flat[s*IDX_W +: IDX_W] == IDX_W'(BAD_IDX));
      end
   endgenerate

   assign any_bad = |hit;
endmodule

// File: rtl/halfsel_mac.sv
module halfsel_mac
   import halfsel_mac_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned BAD_IDX   = 15,
   parameter bit          WORD_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              mode,
   input  logic              sel_a_top,
   input  logic              sel_b_top,
   input  logic              acc_en,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [IDX_W-1:0]  idx_dst,
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [IDX_W-1:0]  idx_b,
   input  logic [IDX_W-1:0]  idx_acc,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] res_out,
   output logic              res_we,
   output logic              unpred,
   output logic              ovf_flag
);
   localparam int unsigned SLOTS = OPND_SLOTS;

   mac_mode_e         mode_e;
   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] acc_sum;
   logic              acc_ovf;
   logic              bad_idx;
   logic [DATA_W-1:0] result_d;
   logic              good_op;
   logic              set_flag;

   assign mode_e = mac_mode_e'(mode);

   hsm_product #(.DATA_W(DATA_W), .WORD_MODE(WORD_MODE)) u_prod (
      .opnd_a(src_a), .opnd_b(src_b), .a_top(sel_a_top), .b_top(sel_b_top),
      .mode_sel(mode_e), .prod_out(prod));

   hsm_acc_add #(.DATA_W(DATA_W)) u_add (
      .lhs(prod), .rhs(acc_in), .sum(acc_sum), .sgn_ovf(acc_ovf));

   hsm_idx_check #(.IDX_W(IDX_W), .SLOTS(SLOTS), .BAD_IDX(BAD_IDX)) u_idx (
      .idx_flat({idx_acc, idx_b, idx_a, idx_dst}),
      .slot_used({acc_en, 3'b111}),
      .any_bad(bad_idx));

   always_comb begin
      good_op  = in_valid && !bad_idx;
      result_d = acc_en ? acc_sum : prod;
      set_flag = good_op && acc_en && acc_ovf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_out  <= '0;
         res_we   <= 1'b0;
         unpred   <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         res_we <= good_op;
         unpred <= in_valid && bad_idx;
         if (good_op) res_out <= result_d;
         if (flag_clr)      ovf_flag <= 1'b0;
         else if (set_flag) ovf_flag <= 1'b1;
      end
   end

   assert_we_excl_unpred_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_we && unpred));

   assert_bad_idx_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && idx_dst == IDX_W'(BAD_IDX)) |=> (unpred && !res_we));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_we && !unpred));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr) |=> ovf_flag);

   assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !ovf_flag);

   assert_noacc_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && !acc_en && !flag_clr) |=> !ovf_flag);
endmodule

// File: tb/sim_halfsel_mac.sv
module sim_halfsel_mac;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, mode = 1'b0, sel_a_top = 1'b0, sel_b_top = 1'b0;
   logic        acc_en = 1'b0, flag_clr = 1'b0;
   logic [31:0] src_a = '0, src_b = '0, acc_in = '0;
   logic [3:0]  idx_dst = 4'd1, idx_a = 4'd2, idx_b = 4'd3, idx_acc = 4'd4;
   logic [31:0] res_out;
   logic        res_we, unpred, ovf_flag;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [31:0] m_res = '0;
   logic        m_we = 0, m_unp = 0, m_flag = 0;

   always #10 clk = ~clk;

   halfsel_mac u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .sel_a_top(sel_a_top), .sel_b_top(sel_b_top), .acc_en(acc_en),
      .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
      .idx_dst(idx_dst), .idx_a(idx_a), .idx_b(idx_b), .idx_acc(idx_acc),
      .flag_clr(flag_clr), .res_out(res_out), .res_we(res_we),
      .unpred(unpred), .ovf_flag(ovf_flag));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic longint pick16(input logic [31:0] w, input bit top);
      shortint h;
      h = top ? shortint'(w[31:16]) : shortint'(w[15:0]);
      return longint'(h);
   endfunction

   // behavioural reference, advanced once per clock
   task automatic model_step();
      longint p, s;
      logic [63:0] pu;
      logic [31:0] r;
      int ri, ai;
      bit badi;
      badi = (idx_dst == 15) || (idx_a == 15) || (idx_b == 15) || (acc_en && idx_acc == 15);
      if (mode) begin
         p  = longint'(int'(src_a)) * pick16(src_b, sel_b_top);
         pu = p;
         r  = pu[47:16];
      end else begin
         p = pick16(src_a, sel_a_top) * pick16(src_b, sel_b_top);
         r = p[31:0];
      end
      bit_ovf: begin
         bit ov;
         ov = 0;
         if (acc_en) begin
            ri = int'(r); ai = int'(acc_in);
            s  = longint'(ri) + longint'(ai);
            ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            r  = s[31:0];
         end
         m_we  = in_valid && !badi;
         m_unp = in_valid && badi;
         if (m_we) m_res = r;
         if (flag_clr) m_flag = 0;
         else if (m_we && acc_en && ov) m_flag = 1;
      end
   endtask

   task automatic compare(input string tag);
      check(res_we === m_we, {tag, " R8 res_we"}, 32'(res_we), 32'(m_we));
      check(unpred === m_unp, "R6 unpred", 32'(unpred), 32'(m_unp));
      check(ovf_flag === m_flag, {tag, " R7 ovf_flag"}, 32'(ovf_flag), 32'(m_flag));
      if (m_we) check(res_out === m_res, {tag, " result"}, res_out, m_res);
   endtask

   task automatic op(input bit v, input bit md, input bit ta, input bit tb, input bit ac,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                     input logic [3:0] d, input logic [3:0] ia, input logic [3:0] ib,
                     input logic [3:0] ic, input bit clr, input string tag);
      in_valid = v; mode = md; sel_a_top = ta; sel_b_top = tb; acc_en = ac;
      src_a = a; src_b = b; acc_in = c; idx_dst = d; idx_a = ia; idx_b = ib;
      idx_acc = ic; flag_clr = clr;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL R8 watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(res_out === 32'd0 && res_we === 1'b0 && unpred === 1'b0 && ovf_flag === 1'b0,
            "R9 reset", {res_out[28:0], res_we, unpred, ovf_flag}, 32'd0);
      rst_n = 1'b1;
      // R1 R2 half selections, no accumulate
      op(1,0,0,0,0, 32'h1234_0003, 32'h5678_FFFE, 0, 1,2,3,4, 0, "R1 bot-bot");
      op(1,0,1,0,0, 32'h8000_0003, 32'h0000_7FFF, 0, 1,2,3,4, 0, "R1 top-bot");
      op(1,0,1,1,0, 32'h8000_7FFF, 32'h8000_0001, 0, 1,2,3,4, 0, "R2 top-top");
      op(1,0,0,1,0, 32'h0000_8000, 32'h7FFF_0000, 0, 1,2,3,4, 0, "R2 bot-top");
      op(0,0,0,0,0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1,2,3,4, 0, "R8 idle");
      // R3 accumulate without and with overflow
      op(1,0,0,0,1, 32'd100, 32'd200, 32'd5, 1,2,3,4, 0, "R3 acc");
      op(1,0,1,1,1, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1,2,3,4, 0, "R3 acc ovf");
      op(0,0,0,0,0, 0, 0, 0, 1,2,3,4, 0, "R7 hold");
      op(1,0,0,0,1, 32'd1, 32'd1, 32'h7FFF_FFFF, 1,2,3,4, 1, "R7 clr wins");
      op(0,0,0,0,0, 0, 0, 0, 1,2,3,4, 0, "R7 after clr");
      // R4 word mode, sel_a_top ignored
      op(1,1,0,0,0, 32'h7FFF_FFFF, 32'h0000_8000, 0, 1,2,3,4, 0, "R4 word bot");
      op(1,1,1,1,0, 32'h8000_0000, 32'h1234_0000, 0, 1,2,3,4, 0, "R4 word top sel_a ignored");
      op(1,1,0,0,0, 32'hDEAD_BEEF, 32'h0000_FFFF, 0, 1,2,3,4, 0, "R4 word neg1");
      // R5 word accumulate
      op(1,1,0,1,1, 32'd65536, 32'h0003_0000, 32'd10, 1,2,3,4, 0, "R5 word acc");
      op(1,1,0,0,1, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_0000, 1,2,3,4, 0, "R5 word acc ovf");
      op(1,1,0,0,0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_0000, 1,2,3,4, 1, "R5 clear");
      op(1,1,0,0,0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 1,2,3,4, 0, "R5 noacc no flag");
      // R6 unpredictable indices
      op(1,0,0,0,1, 32'd1, 32'd1, 32'h7FFF_FFFF, 15,2,3,4, 0, "R6 dst15");
      op(1,0,0,0,0, 32'd3, 32'd3, 0, 1,15,3,4, 0, "R6 a15");
      op(1,1,0,0,0, 32'd3, 32'd3, 0, 1,2,15,4, 0, "R6 b15");
      op(1,0,0,0,1, 32'd1, 32'd1, 32'h7FFF_FFFF, 1,2,3,15, 0, "R6 acc15");
      op(1,0,0,0,0, 32'd7, 32'd9, 0, 1,2,3,15, 0, "R6 acc15 unused");
      // random mix
      for (int i = 0; i < 300; i++) begin
         op($urandom_range(0,3) != 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom, $urandom, $urandom, 4'($urandom_range(0,15)), 4'($urandom_range(0,15)),
            4'($urandom_range(0,15)), 4'($urandom_range(0,15)), $urandom_range(0,9) == 0,
            "R3 R5 random");
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule